// File: doc/BRIEF.md
# Line Output Power Sequencer

This controller owns two control bits of a stereo line output stage: a power-enable bit that powers the output amplifiers, and a power-save bit that holds the outputs quiet while their coupling capacitors charge or discharge. Software, or a higher-level controller, only asks for the output to be turned on or off with single-cycle request pulses. The sequencer turns each request into a fixed order of bit changes, so the capacitors move to or from the common voltage without an audible click.

Every change of the power-enable bit is bracketed by the power-save bit. Power-save is raised first, then power-enable is changed on the next cycle. Power-save then stays high for a settle time long enough for the slowest capacitor ramp. That is 300 ms with a 1 µF capacitor; a typical part ramps in 200 ms. The settle time is given in milliseconds and converted to clock cycles from the clock frequency. Requests that arrive during a sequence are not lost. The most recent request is remembered and served once the running sequence has finished.

Top module: `lineout_pwr_seq`

## Requirements
- R1: After reset, `pwr_en_o` and `pwr_save_o` are 0, `off_o` is 1, and `on_o` and `busy_o` are 0.
- R2: An enable request sampled at clock edge P while off sets `pwr_save_o` at edge P+1 and `pwr_en_o` at edge P+2.
- R3: A disable request sampled at clock edge P while on sets `pwr_save_o` at edge P+1 and clears `pwr_en_o` at edge P+2.
- R4: After each change of `pwr_en_o`, `pwr_save_o` stays 1 for exactly SETTLE_CYCLES clock cycles and then clears. SETTLE_CYCLES = CLK_HZ/1000*SETTLE_MS, and SETTLE_MS defaults to 300.
- R5: `on_o` is 1 exactly when `pwr_en_o` is 1 and `pwr_save_o` is 0, which is the only state in which audio passes.
- R6: `busy_o` is 1 exactly while `pwr_save_o` is 1.
- R7: A request that arrives while busy is held and served after the running sequence ends. When several requests arrive, the last one decides.
- R8: An enable request while on, or a disable request while off, changes neither bit.
- R9: If an enable and a disable request arrive in the same cycle, the disable request wins.
- R10: At most one of the two control bits changes on any clock edge.
- R11: `off_o` is 1 exactly when both control bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_req | input | 1 | One-cycle request to turn the line output on |
| dis_req | input | 1 | One-cycle request to turn the line output off |
| pwr_en_o | output | 1 | Power-enable control bit of the output stage |
| pwr_save_o | output | 1 | Power-save control bit of the output stage |
| busy_o | output | 1 | A power sequence is in progress |
| on_o | output | 1 | Output fully powered and passing audio |
| off_o | output | 1 | Output fully powered down |

## Verification
A behavioural model is compared with the outputs on every clock while several request patterns are applied:
- Isolated enable and disable pulses separate the power-up order from the power-down order and measure the settle length exactly.
- Repeated requests in a settled state show whether a redundant request triggers a spurious sequence.
- A disable sent in the middle of a power-up, and a disable followed by an enable in the middle of a power-down, show whether held requests are kept and whether the last one decides.
- Simultaneous enable and disable pulses expose the priority between the two requests.

// File: rtl/lineout_seq_pkg.sv
// Package: shared state encoding for the line output power sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package lineout_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_UP_SAVE = 3'd1,
        ST_UP_WAIT = 3'd2,
        ST_ON      = 3'd3,
        ST_DN_SAVE = 3'd4,
        ST_DN_WAIT = 3'd5
    } seq_state_e;

    // True for the states inside a power transition.
    function automatic logic in_transition(input seq_state_e s);
        return (s != ST_OFF) && (s != ST_ON);
    endfunction

endpackage

// File: rtl/lo_req_hold.sv
// Module: remembers the most recently requested target power state.
// Assumes: requests are one-cycle pulses. When both arrive together, disable wins.
module lo_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    input  logic dis_req,
    output logic want_on
);

    // Update the target from the latest request, with disable taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_on <= 1'b0;
        end else if (dis_req) begin
            want_on <= 1'b0;
        end else if (en_req) begin
            want_on <= 1'b1;
        end
    end

endmodule

// File: rtl/lo_settle_timer.sv
// Module: down-counter that measures the capacitor settle window.
// Assumes: start is a one-cycle pulse. done is high while the count is zero.
// With LOAD_VAL = N-1, done first appears N-1 cycles after start.
module lo_settle_timer #(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned LOAD_VAL = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    logic [CNT_W-1:0] cnt_q;

    // Load on start, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(LOAD_VAL);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/lo_seq_fsm.sv
// Module: sequencing state machine driving the power-enable and power-save bits.
// Assumes: the settle timer answers done when its window has elapsed.
// Both control bits are registered and change one at a time.
module lo_seq_fsm
    import lineout_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       want_on,
    input  logic       tmr_done,
    output logic       tmr_start,
    output logic       pwr_en_q,
    output logic       pwr_save_q,
    output seq_state_e state_q
);

    seq_state_e state_d;
    logic       pwr_en_d;
    logic       pwr_save_d;

    // Next-state and next-bit decision for the bracketing order.
    always_comb begin
        state_d    = state_q;
        pwr_en_d   = pwr_en_q;
        pwr_save_d = pwr_save_q;
        tmr_start  = 1'b0;
        case (state_q)
            ST_OFF: begin
                if (want_on) begin
                    pwr_save_d = 1'b1;
                    state_d    = ST_UP_SAVE;
                end
            end
            ST_UP_SAVE: begin
                pwr_en_d  = 1'b1;
                tmr_start = 1'b1;
                state_d   = ST_UP_WAIT;
            end
            ST_UP_WAIT: begin
                if (tmr_done) begin
                    pwr_save_d = 1'b0;
                    state_d    = ST_ON;
                end
            end
            ST_ON: begin
                if (!want_on) begin
                    pwr_save_d = 1'b1;
                    state_d    = ST_DN_SAVE;
                end
            end
            ST_DN_SAVE: begin
                pwr_en_d  = 1'b0;
                tmr_start = 1'b1;
                state_d   = ST_DN_WAIT;
            end
            ST_DN_WAIT: begin
                if (tmr_done) begin
                    pwr_save_d = 1'b0;
                    state_d    = ST_OFF;
                end
            end
            default: begin
                pwr_en_d   = 1'b0;
                pwr_save_d = 1'b0;
                state_d    = ST_OFF;
            end
        endcase
    end

    // Register the state and both control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_OFF;
            pwr_en_q   <= 1'b0;
            pwr_save_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            pwr_en_q   <= pwr_en_d;
            pwr_save_q <= pwr_save_d;
        end
    end

endmodule

// File: rtl/lineout_pwr_seq.sv
// Module: top of the line output power sequencer.
// Takes on/off request pulses, brackets every power-enable change with
// power-save, and waits SETTLE_CYCLES before releasing power-save.
// Assumes: CLK_HZ and SETTLE_MS give at least one settle cycle.
module lineout_pwr_seq
    import lineout_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 48_000_000,
    parameter int unsigned SETTLE_MS = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req,
    input  logic dis_req,
    output logic pwr_en_o,
    output logic pwr_save_o,
    output logic busy_o,
    output logic on_o,
    output logic off_o
);

    localparam int unsigned SETTLE_CYCLES = (CLK_HZ / 1000) * SETTLE_MS;
    localparam int unsigned CNT_W         = $clog2(SETTLE_CYCLES + 1);
    localparam int unsigned LOAD_VAL      = SETTLE_CYCLES - 1;

    logic       want_on;
    logic       tmr_start;
    logic       tmr_done;
    seq_state_e state_q;

    lo_req_hold u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_req  (en_req),
        .dis_req (dis_req),
        .want_on (want_on)
    );

    lo_settle_timer #(
        .CNT_W    (CNT_W),
        .LOAD_VAL (LOAD_VAL)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    lo_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .want_on    (want_on),
        .tmr_done   (tmr_done),
        .tmr_start  (tmr_start),
        .pwr_en_q   (pwr_en_o),
        .pwr_save_q (pwr_save_o),
        .state_q    (state_q)
    );

    // Status decoded from the sequencer state.
    assign busy_o = in_transition(state_q);
    assign on_o   = (state_q == ST_ON);
    assign off_o  = (state_q == ST_OFF);

endmodule

// File: rtl/lineout_pwr_seq_chk.sv
// Module: property checker for lineout_pwr_seq, attached by bind.
// Assumes: the same CLK_HZ and SETTLE_MS as the bound instance.
module lineout_pwr_seq_chk #(
    parameter int unsigned CLK_HZ    = 48_000_000,
    parameter int unsigned SETTLE_MS = 300
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_en_o,
    input logic pwr_save_o,
    input logic busy_o,
    input logic on_o,
    input logic off_o
);

    localparam int unsigned SETTLE_CYCLES = (CLK_HZ / 1000) * SETTLE_MS;

    logic        en_prev_q;
    logic [31:0] hold_cnt_q;

    // Count the cycles power-save has been held since power-enable last changed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_prev_q  <= 1'b0;
            hold_cnt_q <= '0;
        end else begin
            en_prev_q <= pwr_en_o;
            if (pwr_en_o != en_prev_q) begin
                hold_cnt_q <= 32'd1;
            end else if (pwr_save_o) begin
                hold_cnt_q <= hold_cnt_q + 32'd1;
            end
        end
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!pwr_en_o && !pwr_save_o && off_o && !busy_o));

    p_up_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en_o) |-> (pwr_save_o && $past(pwr_save_o)));

    p_dn_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en_o) |-> (pwr_save_o && $past(pwr_save_o)));

    p_settle_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_save_o) |-> (hold_cnt_q == 32'(SETTLE_CYCLES)));

    p_on_audio_r5: assert property (@(posedge clk) disable iff (!rst_n)
        on_o == (pwr_en_o && !pwr_save_o));

    p_busy_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == pwr_save_o);

    p_one_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwr_en_o) |-> $stable(pwr_save_o));

    p_off_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
        off_o == (!pwr_en_o && !pwr_save_o));

endmodule

bind lineout_pwr_seq lineout_pwr_seq_chk #(
    .CLK_HZ    (CLK_HZ),
    .SETTLE_MS (SETTLE_MS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_en_o   (pwr_en_o),
    .pwr_save_o (pwr_save_o),
    .busy_o     (busy_o),
    .on_o       (on_o),
    .off_o      (off_o)
);

// File: tb/lineout_pwr_seq_tb.sv
// Bench: a behavioural reference compared on every clock, plus directed checks.
module lineout_pwr_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TB_CLK_HZ  = 2000;
    localparam int TB_SET_MS  = 10;
    localparam int N_SET      = (TB_CLK_HZ / 1000) * TB_SET_MS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_req = 1'b0;
    logic dis_req = 1'b0;
    logic pwr_en_o, pwr_save_o, busy_o, on_o, off_o;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    lineout_pwr_seq #(.CLK_HZ(TB_CLK_HZ), .SETTLE_MS(TB_SET_MS)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .pwr_en_o(pwr_en_o), .pwr_save_o(pwr_save_o), .busy_o(busy_o),
        .on_o(on_o), .off_o(off_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference model: phase 0 off, 1 up-save, 2 up-wait, 3 on, 4 dn-save, 5 dn-wait.
    int m_phase = 0;
    int m_left  = 0;
    bit m_en = 0, m_save = 0, m_want = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_left = 0; m_en = 0; m_save = 0; m_want = 0;
        end else begin
            if (m_phase == 0 && m_want) begin m_save = 1; m_phase = 1; end
            else if (m_phase == 1) begin m_en = 1; m_left = N_SET - 1; m_phase = 2; end
            else if (m_phase == 2) begin
                if (m_left == 0) begin m_save = 0; m_phase = 3; end else m_left--;
            end
            else if (m_phase == 3 && !m_want) begin m_save = 1; m_phase = 4; end
            else if (m_phase == 4) begin m_en = 0; m_left = N_SET - 1; m_phase = 5; end
            else if (m_phase == 5) begin
                if (m_left == 0) begin m_save = 0; m_phase = 0; end else m_left--;
            end
            if (dis_req) m_want = 0;
            else if (en_req) m_want = 1;
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R3", "pwr_en_o vs model", int'(pwr_en_o), int'(m_en));
            check("R2", "pwr_save_o vs model", int'(pwr_save_o), int'(m_save));
            check("R6", "busy_o vs model", int'(busy_o), int'(m_save));
            check("R5", "on_o vs model", int'(on_o), int'(m_phase == 3));
            check("R11", "off_o vs model", int'(off_o), int'(m_phase == 0));
        end
    end

    task automatic pulse(input bit e, input bit d);
        @(negedge clk); en_req = e; dis_req = d;
        @(negedge clk); en_req = 0; dis_req = 0;
    endtask

    // Watch both bits for a few cycles and expect no change.
    task automatic hold_check(input string req, input int en_exp, input int sv_exp);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(req, "pwr_en_o unchanged", int'(pwr_en_o), en_exp);
            check(req, "pwr_save_o unchanged", int'(pwr_save_o), sv_exp);
        end
    endtask

    task automatic wait_state(input bit want_on_st);
        for (int i = 0; i < 4 * N_SET + 20; i++) begin
            if (want_on_st ? on_o : off_o) return;
            @(negedge clk);
        end
        check("R7", "settled state reached", 0, 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++; checks++;
            $display("FAIL R7 watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "pwr_en_o reset", int'(pwr_en_o), 0);
        check("R1", "pwr_save_o reset", int'(pwr_save_o), 0);
        check("R1", "off_o reset", int'(off_o), 1);
        check("R1", "busy_o reset", int'(busy_o), 0);
        rst_n = 1;
        @(negedge clk);

        // R8: disable while off changes nothing
        pulse(0, 1);
        hold_check("R8", 0, 0);

        // R2 and R4: power-up order and settle length
        pulse(1, 0);
        check("R2", "save still low one cycle after capture", int'(pwr_save_o), 0);
        @(negedge clk);
        check("R2", "save set first", int'(pwr_save_o), 1);
        check("R2", "enable not yet set", int'(pwr_en_o), 0);
        @(negedge clk);
        check("R2", "enable set next", int'(pwr_en_o), 1);
        k = 0;
        while (pwr_save_o && k < 4 * N_SET) begin @(negedge clk); k++; end
        check("R4", "power-up settle cycles", k, N_SET);
        check("R5", "on after power-up", int'(on_o), 1);

        // R8: enable while on changes nothing
        pulse(1, 0);
        hold_check("R8", 1, 0);

        // R3 and R4: power-down order and settle length
        pulse(0, 1);
        @(negedge clk);
        check("R3", "save set first", int'(pwr_save_o), 1);
        check("R3", "enable still high", int'(pwr_en_o), 1);
        @(negedge clk);
        check("R3", "enable cleared next", int'(pwr_en_o), 0);
        k = 0;
        while (pwr_save_o && k < 4 * N_SET) begin @(negedge clk); k++; end
        check("R4", "power-down settle cycles", k, N_SET);
        check("R11", "off after power-down", int'(off_o), 1);

        // R7: disable held during power-up, served afterwards
        pulse(1, 0);
        repeat (4) @(negedge clk);
        pulse(0, 1);
        check("R7", "still busy powering up", int'(busy_o), 1);
        wait_state(1);
        check("R7", "reached on first", int'(on_o), 1);
        @(negedge clk);
        check("R7", "held disable starts power-down", int'(pwr_save_o), 1);
        wait_state(0);

        // R7: during power-down, disable then enable; the last one wins
        pulse(1, 0);
        wait_state(1);
        pulse(0, 1);
        repeat (3) @(negedge clk);
        pulse(0, 1);
        pulse(1, 0);
        wait_state(0);
        check("R7", "off reached before re-enable", int'(off_o), 1);
        @(negedge clk);
        check("R7", "held enable restarts power-up", int'(pwr_save_o), 1);
        wait_state(1);
        pulse(0, 1);
        wait_state(0);

        // R9: simultaneous requests while off, disable wins
        pulse(1, 1);
        hold_check("R9", 0, 0);

        // R9: simultaneous requests while on, disable wins
        pulse(1, 0);
        wait_state(1);
        pulse(1, 1);
        @(negedge clk);
        check("R9", "power-down starts", int'(pwr_save_o), 1);
        wait_state(0);
        check("R9", "ends off", int'(off_o), 1);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule